// File: doc/BRIEF.md
# Register-Mapped Control and GPIO Peripheral

This block is a small peripheral on a simple synchronous register bus. It holds a bank of 16-bit control words: a mode word, a clock divider, a power word, a clock-control word and three interrupt words. It also holds a fixed status word and a 16-line general-purpose I/O unit. The interrupt words are storage only, and nothing in the block acts on them. The power word has one automatic rule: writing its trigger bit also forces two flag bits to 1.

The GPIO unit keeps a direction word and a level word. Software writes the level through either of two aliased data offsets, and the written value is masked by the current direction. External input lines change level bits on their edges. The output pins are a registered copy of level AND direction. They are refreshed only in the cycle after a bus write to the direction word or to a data offset, so an input edge on its own leaves the pins as they were.

Reads are combinational: `bus_rdata` shows the register selected by `bus_addr` in the same cycle. A write takes effect at the next rising clock edge.

Top module: `ctlgpio_regs`

## Requirements
- R1: After reset, the status word (offset 0x08) reads 0x0002, every other register reads 0x0000, and `gpio_out` is 0x0000.
- R2: Only `bus_addr[5:0]` is decoded. An address whose upper bits are non-zero reaches the same register as its low six bits.
- R3: Only `bus_wdata[15:0]` is stored. Offsets 0x00 (mode), 0x04 (clock divider), 0x10 (clock control), 0x14 (interrupt request), 0x18 (interrupt mask) and 0x1C (interrupt status) read back the last value written to them.
- R4: A write to offset 0x0C (power) with bit 7 set stores the value with bits 15 and 6 also set to 1. With bit 7 clear, the value is stored as written.
- R5: Offset 0x08 always reads 0x0002. Bus writes to it have no effect.
- R6: A write to offset 0x24 or 0x28 stores (write data AND direction) into the level word. The direction word is at offset 0x20 and reads back as written.
- R7: Reads of offset 0x24 and offset 0x28 both return the level word.
- R8: In the cycle after a write to offset 0x20, 0x24 or 0x28, `gpio_out` equals level AND direction, using the values after that write. In every other cycle it holds its previous value.
- R9: A rising edge on `gpio_in[i]` sets level bit i, and a falling edge clears it, one cycle later. The edge on its own does not change `gpio_out`. The edge detector starts from all-zero at reset.
- R10: Reads of any offset not listed above (for example 0x01, 0x2C or 0x3C) return 0x0000. Writes to those offsets change no register.
- R11: When an input edge and a bus write to offset 0x24 or 0x28 fall in the same cycle, the bus write sets the whole level word and the edge is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Register byte address; only the low six bits are decoded |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | WDATA_W (32) | Write data; the low 16 bits are used |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| gpio_in | input | GPIO_N (16) | External input lines, edge-sensed into the level word |
| gpio_out | output | GPIO_N (16) | Registered level AND direction |

## Verification
An input edge on `gpio_in` and a bus write to the direction word or a data offset can land in the same cycle. Both then try to set the next level word. The bench forces this overlap deliberately, toggling input lines in the same cycle as a data-offset write and in the same cycle as a direction write. It also keeps both kinds of event running together through a long stretch of mixed random traffic. A behavioural model applies the edge first and the bus write over it, and it is compared against `bus_rdata` and `gpio_out` every cycle. This shows whether the edge was dropped (data write) or kept and folded into the refreshed output (direction write).

// File: rtl/ctlgpio_pkg.sv
// ctlgpio_pkg
// Shared constants for the control/GPIO register block: register width,
// decoded offset width, register offsets and the power-word rule.
// Assumes: every register is REG_W bits wide and byte offsets are word aligned.
package ctlgpio_pkg;

    localparam int REG_W  = 16;
    localparam int OFFS_W = 6;

    localparam logic [OFFS_W-1:0] OFF_MODE = 6'h00;
    localparam logic [OFFS_W-1:0] OFF_CDIV = 6'h04;
    localparam logic [OFFS_W-1:0] OFF_STAT = 6'h08;
    localparam logic [OFFS_W-1:0] OFF_PWR  = 6'h0C;
    localparam logic [OFFS_W-1:0] OFF_CCTL = 6'h10;
    localparam logic [OFFS_W-1:0] OFF_IREQ = 6'h14;
    localparam logic [OFFS_W-1:0] OFF_IMSK = 6'h18;
    localparam logic [OFFS_W-1:0] OFF_ISTS = 6'h1C;
    localparam logic [OFFS_W-1:0] OFF_GDIR = 6'h20;
    localparam logic [OFFS_W-1:0] OFF_GWR  = 6'h24;
    localparam logic [OFFS_W-1:0] OFF_GRD  = 6'h28;

    localparam logic [REG_W-1:0] STAT_RESET   = 16'h0002;
    localparam int               PWR_TRIG_BIT = 7;
    localparam logic [REG_W-1:0] PWR_SET_MASK = 16'h8040;

    // Number of plain read/write storage words (mode, divider, clock control,
    // interrupt request, mask, status).
    localparam int NPLAIN = 6;

    // Offset of plain storage word i.
    function automatic logic [OFFS_W-1:0] plain_off(input int i);
        case (i)
            0:       return OFF_MODE;
            1:       return OFF_CDIV;
            2:       return OFF_CCTL;
            3:       return OFF_IREQ;
            4:       return OFF_IMSK;
            default: return OFF_ISTS;
        endcase
    endfunction

    // True when the offset selects either GPIO data alias.
    function automatic logic is_gpio_data(input logic [OFFS_W-1:0] off);
        return (off == OFF_GWR) || (off == OFF_GRD);
    endfunction

endpackage

// File: rtl/ctlgpio_ctl_bank.sv
// ctlgpio_ctl_bank
// Holds the plain control words and the power word. The plain words store
// whatever is written to them. The power word forces its flag bits when
// the trigger bit is written as 1.
// Assumes: wr_val has already been cut to REG_W bits by the caller.
module ctlgpio_ctl_bank
    import ctlgpio_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [OFFS_W-1:0]            wr_off,
    input  logic [REG_W-1:0]             wr_val,
    output logic [NPLAIN-1:0][REG_W-1:0] plain_q,
    output logic [REG_W-1:0]             pwr_q
);

    // One storage word per plain offset.
    for (genvar gi = 0; gi < NPLAIN; gi++) begin : g_plain
        localparam logic [OFFS_W-1:0] MY_OFF = plain_off(gi);

        // Load the word when its own offset is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                plain_q[gi] <= '0;
            else if (wr_en && (wr_off == MY_OFF))
                plain_q[gi] <= wr_val;
        end
    end

    logic             pwr_hit;
    logic [REG_W-1:0] pwr_next;

    // Power value to store: the written value, plus the forced flags when
    // the trigger bit is set.
    always_comb begin
        pwr_hit  = wr_en && (wr_off == OFF_PWR);
        pwr_next = wr_val;
        if (wr_val[PWR_TRIG_BIT])
            pwr_next = wr_val | PWR_SET_MASK;
    end

    // Power word register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwr_q <= '0;
        else if (pwr_hit)
            pwr_q <= pwr_next;
    end

    // R4
    pwr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_off) == OFF_PWR && $past(wr_val[PWR_TRIG_BIT]))
        |-> ((pwr_q & PWR_SET_MASK) == PWR_SET_MASK) && ((pwr_q | PWR_SET_MASK) == ($past(wr_val) | PWR_SET_MASK)));

    // R4
    pwr_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_off) == OFF_PWR && !$past(wr_val[PWR_TRIG_BIT]))
        |-> pwr_q == $past(wr_val));

endmodule

// File: rtl/ctlgpio_gpio_unit.sv
// ctlgpio_gpio_unit
// Holds the GPIO direction and level words, senses edges on the external
// inputs, and drives registered outputs equal to level AND direction.
// The outputs are refreshed only in the cycle after a direction write or
// a data-offset write. A bus data write overrides an input edge in the
// same cycle.
// Assumes: GPIO_N <= REG_W. The edge detector resets to all-zero.
module ctlgpio_gpio_unit
    import ctlgpio_pkg::*;
#(
    parameter int GPIO_N = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFFS_W-1:0] wr_off,
    input  logic [REG_W-1:0]  wr_val,
    input  logic [GPIO_N-1:0] ext_in,
    output logic [GPIO_N-1:0] dir_q,
    output logic [GPIO_N-1:0] level_q,
    output logic [GPIO_N-1:0] gpio_out
);

    logic [GPIO_N-1:0] prev_in;
    logic [GPIO_N-1:0] edge_seen;
    logic [GPIO_N-1:0] level_next;
    logic [GPIO_N-1:0] dir_next;
    logic              wr_dir;
    logic              wr_dat;
    logic              out_upd;

    // Decode the GPIO writes, then build the next level and direction:
    // input edges first, a bus data write over them.
    always_comb begin
        wr_dir     = wr_en && (wr_off == OFF_GDIR);
        wr_dat     = wr_en && is_gpio_data(wr_off);
        out_upd    = wr_dir || wr_dat;
        edge_seen  = ext_in ^ prev_in;
        level_next = (level_q & ~edge_seen) | (ext_in & edge_seen);
        dir_next   = dir_q;
        if (wr_dir)
            dir_next = wr_val[GPIO_N-1:0];
        if (wr_dat)
            level_next = wr_val[GPIO_N-1:0] & dir_q;
    end

    // State registers: edge history, level, direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_in <= '0;
            level_q <= '0;
            dir_q   <= '0;
        end else begin
            prev_in <= ext_in;
            level_q <= level_next;
            dir_q   <= dir_next;
        end
    end

    // Output register, loaded only after a relevant bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gpio_out <= '0;
        else if (out_upd)
            gpio_out <= level_next & dir_next;
    end

    // R6 R11
    data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && is_gpio_data($past(wr_off)))
        |-> level_q == ($past(wr_val[GPIO_N-1:0]) & $past(dir_q)));

    // R8
    out_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(out_upd)) |-> gpio_out == (level_q & dir_q));

    // R8 R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(out_upd)) |-> $stable(gpio_out));

    // R9
    level_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_dat))
        |-> ((level_q ^ $past(level_q)) & ~($past(ext_in) ^ $past(prev_in))) == '0);

endmodule

// File: rtl/ctlgpio_read_mux.sv
// ctlgpio_read_mux
// Combinational read path: selects the register addressed by the decoded
// offset and returns zero for any offset that is not mapped.
// Assumes: GPIO words are zero-extended to REG_W.
module ctlgpio_read_mux
    import ctlgpio_pkg::*;
#(
    parameter int GPIO_N = 16
) (
    input  logic [OFFS_W-1:0]            rd_off,
    input  logic [NPLAIN-1:0][REG_W-1:0] plain_q,
    input  logic [REG_W-1:0]             pwr_q,
    input  logic [GPIO_N-1:0]            dir_q,
    input  logic [GPIO_N-1:0]            level_q,
    output logic [REG_W-1:0]             rdata
);

    logic [REG_W-1:0] dir_ext;
    logic [REG_W-1:0] level_ext;

    // Zero-extend the GPIO words to the register width.
    always_comb begin
        dir_ext                = '0;
        level_ext              = '0;
        dir_ext[GPIO_N-1:0]    = dir_q;
        level_ext[GPIO_N-1:0]  = level_q;
    end

    // Offset decode; unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NPLAIN; i++)
            if (rd_off == plain_off(i))
                rdata = plain_q[i];
        case (rd_off)
            OFF_STAT:         rdata = STAT_RESET;
            OFF_PWR:          rdata = pwr_q;
            OFF_GDIR:         rdata = dir_ext;
            OFF_GWR, OFF_GRD: rdata = level_ext;
            default: ;
        endcase
    end

endmodule

// File: rtl/ctlgpio_regs.sv
// ctlgpio_regs
// Top level of the register-mapped control and GPIO peripheral. Decodes
// the low six address bits, cuts write data to the register width, and
// joins the control bank, the GPIO unit and the read multiplexer.
// Assumes: single-cycle synchronous bus; reads are combinational, writes
// take effect at the next rising edge.
module ctlgpio_regs
    import ctlgpio_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int WDATA_W = 32,
    parameter int GPIO_N  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [WDATA_W-1:0] bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [GPIO_N-1:0]  gpio_in,
    output logic [GPIO_N-1:0]  gpio_out
);

    logic [OFFS_W-1:0]            off;
    logic [REG_W-1:0]             wval;
    logic [NPLAIN-1:0][REG_W-1:0] plain_q;
    logic [REG_W-1:0]             pwr_q;
    logic [GPIO_N-1:0]            dir_q;
    logic [GPIO_N-1:0]            level_q;
    logic                         unused_hi;

    // Decode the offset and cut the write data; the upper bits are dropped.
    assign off       = bus_addr[OFFS_W-1:0];
    assign wval      = bus_wdata[REG_W-1:0];
    assign unused_hi = ^{bus_addr[ADDR_W-1:OFFS_W], bus_wdata[WDATA_W-1:REG_W]};

    ctlgpio_ctl_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .wr_off  (off),
        .wr_val  (wval),
        .plain_q (plain_q),
        .pwr_q   (pwr_q)
    );

    ctlgpio_gpio_unit #(.GPIO_N(GPIO_N)) u_gpio (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_we),
        .wr_off   (off),
        .wr_val   (wval),
        .ext_in   (gpio_in),
        .dir_q    (dir_q),
        .level_q  (level_q),
        .gpio_out (gpio_out)
    );

    ctlgpio_read_mux #(.GPIO_N(GPIO_N)) u_rmux (
        .rd_off  (off),
        .plain_q (plain_q),
        .pwr_q   (pwr_q),
        .dir_q   (dir_q),
        .level_q (level_q),
        .rdata   (bus_rdata)
    );

    // R5
    status_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[OFFS_W-1:0] == OFF_STAT) |-> bus_rdata == STAT_RESET);

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[OFFS_W-1:0] > OFF_GRD) |-> bus_rdata == '0);

    // R7
    alias_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_gpio_data(bus_addr[OFFS_W-1:0]) |-> bus_rdata[GPIO_N-1:0] == level_q);

endmodule

// File: tb/sim_ctlgpio_regs.sv
module sim_ctlgpio_regs;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] gpio_in = '0;
    logic [15:0] gpio_out;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    // Behavioural reference state.
    logic [15:0] mreg [0:15];
    logic [15:0] m_dir, m_level, m_out, m_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctlgpio_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gpio_in(gpio_in), .gpio_out(gpio_out)
    );

    function automatic logic [15:0] exp_rd(input logic [11:0] a);
        logic [5:0] o = a[5:0];
        case (o)
            6'h00, 6'h04, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h1C: return mreg[o[5:2]];
            6'h08:        return 16'h0002;
            6'h20:        return m_dir;
            6'h24, 6'h28: return m_level;
            default:      return 16'h0000;
        endcase
    endfunction

    // Reference model step at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mreg[i] = 16'h0;
            m_dir = 0; m_level = 0; m_out = 0; m_prev = 0;
        end else begin
            logic [15:0] lv, w;
            logic        upd;
            logic [5:0]  o;
            lv  = m_level;
            upd = 1'b0;
            for (int b = 0; b < 16; b++)
                if (gpio_in[b] != m_prev[b]) lv[b] = gpio_in[b];
            if (bus_we) begin
                o = bus_addr[5:0];
                w = bus_wdata[15:0];
                case (o)
                    6'h00, 6'h04, 6'h10, 6'h14, 6'h18, 6'h1C: mreg[o[5:2]] = w;
                    6'h0C: mreg[3] = w[7] ? (w | 16'h8040) : w;
                    6'h20: begin m_dir = w; upd = 1'b1; end
                    6'h24, 6'h28: begin lv = w & m_dir; upd = 1'b1; end
                    default: ;
                endcase
            end
            m_level = lv;
            if (upd) m_out = lv & m_dir;
            m_prev = gpio_in;
        end
    end

    task automatic compare();
        logic [15:0] e = exp_rd(bus_addr);
        n_checks++;
        if (bus_rdata !== e) begin
            n_fails++;
            $display("FAIL %s rdata addr=%h actual=%h expected=%h", cur_req, bus_addr, bus_rdata, e);
        end
        n_checks++;
        if (gpio_out !== m_out) begin
            n_fails++;
            $display("FAIL %s gpio_out actual=%h expected=%h", cur_req, gpio_out, m_out);
        end
    endtask

    // One bus cycle: drive at the falling edge, compare a quarter period later.
    task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] wd, input logic [15:0] ext);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = wd; gpio_in = ext;
        #(CLK_PERIOD/4);
        if (rst_n) compare();
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] wd);
        cyc(1'b1, a, wd, gpio_in);
    endtask

    // Literal expectation, independent of the model.
    task automatic expect_rd(input logic [11:0] a, input logic [15:0] v);
        cyc(1'b0, a, 32'h0, gpio_in);
        n_checks++;
        if (bus_rdata !== v) begin
            n_fails++;
            $display("FAIL %s literal addr=%h actual=%h expected=%h", cur_req, a, bus_rdata, v);
        end
    endtask

    task automatic expect_out(input logic [15:0] v);
        n_checks++;
        if (gpio_out !== v) begin
            n_fails++;
            $display("FAIL %s literal gpio_out actual=%h expected=%h", cur_req, gpio_out, v);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc(1'b0, 12'h0, 32'h0, 16'h0);
        @(negedge clk); rst_n = 1'b1;

        cur_req = "R1";
        foreach (mreg[i]) expect_rd(12'(i*4), (i == 2) ? 16'h0002 : 16'h0000);
        expect_out(16'h0000);

        cur_req = "R3";
        wr(12'h000, 32'hABCD_1234); expect_rd(12'h000, 16'h1234);
        wr(12'h010, 32'h0000_5A5A); wr(12'h014, 32'hFFFF_0001);
        wr(12'h018, 32'h1234_8000); wr(12'h01C, 32'h0000_00FF);
        expect_rd(12'h010, 16'h5A5A); expect_rd(12'h014, 16'h0001);
        expect_rd(12'h018, 16'h8000); expect_rd(12'h01C, 16'h00FF);

        cur_req = "R2";
        wr(12'h7C4, 32'h0000_BEEF); expect_rd(12'h004, 16'hBEEF);
        expect_rd(12'hF44, 16'hBEEF);

        cur_req = "R4";
        wr(12'h00C, 32'h0000_0080); expect_rd(12'h00C, 16'h80C0);
        wr(12'h00C, 32'h0000_0F7F); expect_rd(12'h00C, 16'h0F7F);
        wr(12'h00C, 32'h0000_1281); expect_rd(12'h00C, 16'h92C1);

        cur_req = "R5";
        wr(12'h008, 32'h0000_FFFF); expect_rd(12'h008, 16'h0002);

        cur_req = "R6";
        wr(12'h020, 32'h0000_00FF); expect_rd(12'h020, 16'h00FF);
        wr(12'h024, 32'h0000_FFFF); expect_rd(12'h024, 16'h00FF);
        expect_out(16'h00FF);
        wr(12'h028, 32'h0000_A5A5);

        cur_req = "R7";
        expect_rd(12'h024, 16'h00A5); expect_rd(12'h028, 16'h00A5);

        cur_req = "R8";
        wr(12'h020, 32'h0000_F0F0);
        cyc(1'b0, 12'h020, 32'h0, gpio_in); expect_out(16'h00A0);
        repeat (4) cyc(1'b0, 12'h000, 32'h0, gpio_in);
        expect_out(16'h00A0);

        cur_req = "R9";
        cyc(1'b0, 12'h024, 32'h0, 16'h0F00);
        cyc(1'b0, 12'h024, 32'h0, 16'h0F00);
        expect_rd(12'h024, 16'h0FA5); expect_out(16'h00A0);
        cyc(1'b0, 12'h024, 32'h0, 16'h0E00);
        expect_rd(12'h024, 16'h0EA5); expect_out(16'h00A0);
        wr(12'h020, 32'h0000_F0F0);
        cyc(1'b0, 12'h000, 32'h0, gpio_in); expect_out(16'h00A0 | 16'h0000);

        cur_req = "R10";
        expect_rd(12'h02C, 16'h0); expect_rd(12'h03C, 16'h0); expect_rd(12'h001, 16'h0);
        wr(12'h02C, 32'h0000_FFFF); wr(12'h001, 32'h0000_FFFF); wr(12'h03C, 32'h0000_FFFF);
        expect_rd(12'h000, 16'h1234); expect_rd(12'h004, 16'hBEEF);
        expect_rd(12'h020, 16'hF0F0); expect_rd(12'h028, 16'h0EA5);
        expect_rd(12'h00C, 16'h92C1);

        cur_req = "R11";
        wr(12'h020, 32'h0000_FFFF);
        cyc(1'b1, 12'h024, 32'h0000_0003, 16'hF0E0);
        expect_rd(12'h024, 16'h0003);
        expect_out(16'h0003);
        cyc(1'b1, 12'h020, 32'h0000_FFFF, 16'h00E0);
        expect_rd(12'h024, 16'h0003);

        cur_req = "R11";
        for (int k = 0; k < 4000; k++) begin
            logic [11:0] a;
            logic [15:0] ext = gpio_in;
            case ($urandom_range(0, 13))
                0: a = 12'h000; 1: a = 12'h004; 2: a = 12'h008; 3: a = 12'h00C;
                4: a = 12'h010; 5: a = 12'h014; 6: a = 12'h018; 7: a = 12'h01C;
                8, 9: a = 12'h020; 10: a = 12'h024; 11: a = 12'h028;
                12: a = 12'h030; default: a = 12'hAE4;
            endcase
            if ($urandom_range(0, 2) == 0) ext = ext ^ 16'($urandom);
            cyc($urandom_range(0, 1) == 1, a, $urandom, ext);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule